// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

A small word memory for thread synchronization. Each 64-bit word has one tag bit that records whether the word is full or empty. Requesters send synchronizing loads and stores. Each access has a tag condition it needs before it can run and a tag value it leaves behind.

An access whose condition does not hold is not rejected. It is parked in a hardware wait queue and retried whenever a tag may have changed. When the queue holds the maximum number of entries, the request port holds off new requests. Every completed access returns a response carrying the requester's identifier. A separate preload port can write a word and mark it full without any condition.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every tag is empty, `req_ready` is high and `rsp_valid` is low.
- R2: Opcode 0 (read-keep) waits for full, returns the word and leaves the tag full. Opcode 1 (read-take) waits for full, returns the word and clears the tag to empty.
- R3: Opcode 2 (put-fill) writes at once and sets full. Opcode 3 (put-when-empty) waits for empty, writes and sets full. Opcode 4 (put-clear) writes at once and sets empty. A store's response returns the written data.
- R4: An access whose condition does not hold gives no response and changes nothing until the tag reaches the needed state. It never completes with its condition unmet.
- R5: Each completion yields exactly one response, one cycle later, with the requester's identifier. At most one access completes per cycle.
- R6: Queued accesses are retried in arrival order. Among the waiters whose condition holds, the oldest completes first. A new request to a word that already has waiters joins the queue behind them.
- R7: The queue holds 8 entries. `req_ready` is low exactly while all 8 are in use, and it rises again once an entry completes.
- R8: A preload (`init_en`) writes `init_data` and sets the tag full in the next cycle, which releases waiters on that word.
- R9: Opcodes 5 to 7 are accepted and discarded: no response, and no change to data or tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (queue not full) |
| req_op | input | 3 | Access opcode (0..4 valid) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_id | input | ID_W | Requester identifier |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_data | output | DATA_W | Loaded word, or the stored data for stores |
| rsp_id | output | ID_W | Identifier of the completed request |
| init_en | input | 1 | Preload strobe |
| init_addr | input | ADDR_W | Preload address |
| init_data | input | DATA_W | Preload data |

## Verification
The tag assertions take for granted that a preload does not hit the word being completed in the same cycle, so they skip that cycle. They also assume that only opcodes 0 to 4 can reach the completion path.

The stimulus places one request at a time and waits for its outcome before the next. The only exceptions are the ordering and queue-full sequences. In those sequences, waiters are always released later, either by a store or by the preload port, so the bench never depends on a request that cannot drain.

The sweep covers every valid opcode against both tag states on every word. After each step it reads back the resulting tag and data through an ordinary read-take probe.

// File: rtl/fe_sync_mem.sv
module fe_sync_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 64,
  parameter int ID_W   = 4,
  parameter int QDEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ID_W-1:0]   rsp_id,
  input  logic              init_en,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [DATA_W-1:0] init_data
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int CNT_W = $clog2(QDEPTH + 1);
  localparam int QI_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  localparam logic [2:0] OP_RDKEEP = 3'd0;
  localparam logic [2:0] OP_RDTAKE = 3'd1;
  localparam logic [2:0] OP_PUTFIL = 3'd2;
  localparam logic [2:0] OP_PUTWE  = 3'd3;
  localparam logic [2:0] OP_PUTCLR = 3'd4;

  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  tag;

  logic [2:0]        q_op   [QDEPTH];
  logic [ADDR_W-1:0] q_addr [QDEPTH];
  logic [DATA_W-1:0] q_data [QDEPTH];
  logic [ID_W-1:0]   q_id   [QDEPTH];
  logic [CNT_W-1:0]  q_cnt;

  function automatic logic cond_ok(input logic [2:0] op, input logic t);
    case (op)
      OP_RDKEEP, OP_RDTAKE: cond_ok = t;
      OP_PUTWE:             cond_ok = !t;
      OP_PUTFIL, OP_PUTCLR: cond_ok = 1'b1;
      default:              cond_ok = 1'b0;
    endcase
  endfunction

  function automatic logic after_tag(input logic [2:0] op);
    after_tag = (op == OP_RDKEEP) || (op == OP_PUTFIL) || (op == OP_PUTWE);
  endfunction

  logic            q_hit;
  logic [QI_W-1:0] q_sel;
  logic            addr_waiting;

  always_comb begin
    q_hit = 1'b0;
    q_sel = '0;
    addr_waiting = 1'b0;
    for (int i = QDEPTH - 1; i >= 0; i--) begin
      if (i < int'(q_cnt) && cond_ok(q_op[i], tag[q_addr[i]])) begin
        q_hit = 1'b1;
        q_sel = QI_W'(i);
      end
      if (i < int'(q_cnt) && q_addr[i] == req_addr)
        addr_waiting = 1'b1;
    end
  end

  assign req_ready = (q_cnt != CNT_W'(QDEPTH));

  logic accept, op_legal, new_direct, new_enq, cmp_fire;
  assign accept     = req_valid && req_ready;
  assign op_legal   = (req_op <= OP_PUTCLR);
  assign new_direct = accept && op_legal && !q_hit && !addr_waiting &&
                      cond_ok(req_op, tag[req_addr]);
  assign new_enq    = accept && op_legal && !new_direct;
  assign cmp_fire   = q_hit || new_direct;

  logic [2:0]        cmp_op;
  logic [ADDR_W-1:0] cmp_addr;
  logic [DATA_W-1:0] cmp_data;
  logic [ID_W-1:0]   cmp_id;
  assign cmp_op   = q_hit ? q_op[q_sel]   : req_op;
  assign cmp_addr = q_hit ? q_addr[q_sel] : req_addr;
  assign cmp_data = q_hit ? q_data[q_sel] : req_wdata;
  assign cmp_id   = q_hit ? q_id[q_sel]   : req_id;

  logic cmp_is_load;
  assign cmp_is_load = (cmp_op == OP_RDKEEP) || (cmp_op == OP_RDTAKE);

  logic [CNT_W-1:0] wpos;
  assign wpos = q_cnt - CNT_W'(q_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_cnt <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        q_op[i]   <= '0;
        q_addr[i] <= '0;
        q_data[i] <= '0;
        q_id[i]   <= '0;
      end
    end else begin
      if (q_hit) begin
        for (int i = 0; i < QDEPTH - 1; i++) begin
          if (i >= int'(q_sel)) begin
            q_op[i]   <= q_op[i+1];
            q_addr[i] <= q_addr[i+1];
            q_data[i] <= q_data[i+1];
            q_id[i]   <= q_id[i+1];
          end
        end
      end
      if (new_enq) begin
        q_op[QI_W'(wpos)]   <= req_op;
        q_addr[QI_W'(wpos)] <= req_addr;
        q_data[QI_W'(wpos)] <= req_wdata;
        q_id[QI_W'(wpos)]   <= req_id;
      end
      q_cnt <= q_cnt - CNT_W'(q_hit) + CNT_W'(new_enq);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag <= '0;
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_id    <= '0;
    end else begin
      rsp_valid <= cmp_fire;
      if (cmp_fire) begin
        rsp_id   <= cmp_id;
        rsp_data <= cmp_is_load ? mem[cmp_addr] : cmp_data;
        if (!cmp_is_load) mem[cmp_addr] <= cmp_data;
        tag[cmp_addr] <= after_tag(cmp_op);
      end
      if (init_en) begin
        mem[init_addr] <= init_data;
        tag[init_addr] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk #(
  parameter int ADDR_W = 4,
  parameter int QDEPTH = 8,
  parameter int CNT_W  = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmp_fire,
  input logic [2:0]               cmp_op,
  input logic [ADDR_W-1:0]        cmp_addr,
  input logic [(1<<ADDR_W)-1:0]   tag,
  input logic                     rsp_valid,
  input logic                     req_ready,
  input logic [CNT_W-1:0]         q_cnt,
  input logic                     init_en,
  input logic [ADDR_W-1:0]        init_addr
);
  logic exp_full, clash;
  assign exp_full = (cmp_op == 3'd0) || (cmp_op == 3'd2) || (cmp_op == 3'd3);
  assign clash    = init_en && (init_addr == cmp_addr);

  // R4
  load_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire && (cmp_op == 3'd0 || cmp_op == 3'd1) |-> tag[cmp_addr]);

  // R4
  putwe_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire && cmp_op == 3'd3 |-> !tag[cmp_addr]);

  // R2
  post_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire && !clash |=> tag[$past(cmp_addr)] == $past(exp_full));

  // R5
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> rsp_valid);

  // R7
  ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> q_cnt == CNT_W'(QDEPTH));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CNT_W'(QDEPTH));

  // R8
  init_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_en |=> tag[$past(init_addr)]);

  // R9
  legal_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |-> cmp_op <= 3'd4);
endmodule

bind fe_sync_mem fe_sync_mem_chk #(
  .ADDR_W(ADDR_W), .QDEPTH(QDEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_fire(cmp_fire), .cmp_op(cmp_op),
  .cmp_addr(cmp_addr), .tag(tag), .rsp_valid(rsp_valid),
  .req_ready(req_ready), .q_cnt(q_cnt), .init_en(init_en),
  .init_addr(init_addr)
);

// File: tb/test_fe_sync_mem.sv
module test_fe_sync_mem;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 64;
  localparam int ID_W   = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [2:0] req_op = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [DATA_W-1:0] req_wdata = 0;
  logic [ID_W-1:0] req_id = 0;
  logic rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic [ID_W-1:0] rsp_id;
  logic init_en = 0;
  logic [ADDR_W-1:0] init_addr = 0;
  logic [DATA_W-1:0] init_data = 0;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  fe_sync_mem i_fe_sync_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_id(rsp_id),
    .init_en(init_en), .init_addr(init_addr), .init_data(init_data)
  );

  logic [DATA_W-1:0] got_data[$];
  logic [ID_W-1:0]   got_id[$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      got_data.push_back(rsp_data);
      got_id.push_back(rsp_id);
    end
  end

  task automatic chk(input logic ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic [ID_W-1:0] id);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d; req_id = id;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic preload(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    init_en = 1; init_addr = a; init_data = d;
    @(negedge clk);
    init_en = 0;
  endtask

  task automatic expect_rsp(input logic [ID_W-1:0] id, input logic [DATA_W-1:0] d,
                            input string req);
    logic [ID_W-1:0] gi;
    logic [DATA_W-1:0] gd;
    int n = 0;
    while (got_id.size() == 0 && n < 12) begin @(negedge clk); n++; end
    if (got_id.size() == 0) begin
      chk(1'b0, req, 64'hdead, {60'd0, id});
    end else begin
      gi = got_id.pop_front();
      gd = got_data.pop_front();
      chk(gi == id, req, {60'd0, gi}, {60'd0, id});
      chk(gd == d, req, gd, d);
    end
  endtask

  task automatic expect_none(input int n, input string req);
    repeat (n) @(negedge clk);
    chk(got_id.size() == 0, req, 64'(got_id.size()), 64'd0);
  endtask

  task automatic make_empty(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    send(3'd4, a, d, 4'd13);
    expect_rsp(4'd13, d, "R3 put-clear prep");
  endtask

  // read-take probe: reports tag and data, leaves the word empty
  task automatic probe(input logic [ADDR_W-1:0] a, input logic exp_full,
                       input logic [DATA_W-1:0] exp_d, input string req);
    send(3'd1, a, 64'd0, 4'd15);
    repeat (3) @(negedge clk);
    if (got_id.size() != 0) begin
      chk(exp_full == 1'b1, req, 64'd1, {63'd0, exp_full});
      expect_rsp(4'd15, exp_d, req);
    end else begin
      chk(exp_full == 1'b0, req, 64'd0, {63'd0, exp_full});
      send(3'd2, a, 64'd0, 4'd14);
      expect_rsp(4'd14, 64'd0, req);
      expect_rsp(4'd15, 64'd0, req);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 ready after reset", {63'd0, req_ready}, 64'd1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", {63'd0, rsp_valid}, 64'd0);
    for (int a = 0; a < 16; a++) probe(ADDR_W'(a), 1'b0, 64'd0, "R1 tag empty at reset");

    // R2 R3 R4 sweep: every word, every legal opcode, both tag states
    for (int a = 0; a < 16; a++) begin
      for (int op = 0; op < 5; op++) begin
        for (int pre = 0; pre < 2; pre++) begin
          logic [DATA_W-1:0] d1, d2, d3, fin_d;
          logic ok, fin_full, is_ld;
          d1 = 64'hA5A5_0000_0000_0000 + 64'(a) * 64'h1000 + 64'(op) * 16 + 64'(pre);
          d2 = ~d1;
          d3 = d1 ^ 64'h0F0F_0000_0000_0000;
          is_ld = (op <= 1);
          if (pre == 1) preload(ADDR_W'(a), d1); else make_empty(ADDR_W'(a), d1);
          ok = (op <= 1) ? (pre == 1) : (op == 3) ? (pre == 0) : 1'b1;
          send(3'(op), ADDR_W'(a), d2, ID_W'(op));
          if (ok) begin
            expect_rsp(ID_W'(op), is_ld ? d1 : d2, is_ld ? "R2 load immediate" : "R3 store immediate");
            fin_full = (op == 0) || (op == 2) || (op == 3);
            fin_d = is_ld ? d1 : d2;
          end else begin
            expect_none(4, "R4 blocked access gives no response");
            if (is_ld) begin
              send(3'd2, ADDR_W'(a), d3, 4'd12);
              expect_rsp(4'd12, d3, "R3 release store");
              expect_rsp(ID_W'(op), d3, "R4 load released");
              fin_full = (op == 0);
              fin_d = d3;
            end else begin
              send(3'd1, ADDR_W'(a), 64'd0, 4'd12);
              expect_rsp(4'd12, d1, "R2 release take");
              expect_rsp(ID_W'(op), d2, "R4 put-when-empty released");
              fin_full = 1'b1;
              fin_d = d2;
            end
          end
          probe(ADDR_W'(a), fin_full, fin_d, is_ld ? "R2 tag after load" : "R3 tag after store");
        end
      end
    end

    // R9: illegal opcodes discarded
    preload(4'd2, 64'h1234_5678_9ABC_DEF0);
    for (int op = 5; op < 8; op++) send(3'(op), 4'd2, 64'hFFFF, 4'd7);
    expect_none(4, "R9 no response for illegal opcode");
    probe(4'd2, 1'b1, 64'h1234_5678_9ABC_DEF0, "R9 word unchanged");

    // R6: waiters served in arrival order, store joins behind them
    send(3'd1, 4'd6, 64'd0, 4'd1);
    send(3'd1, 4'd6, 64'd0, 4'd2);
    send(3'd1, 4'd6, 64'd0, 4'd3);
    expect_none(3, "R4 three takers wait");
    send(3'd2, 4'd6, 64'hAAAA, 4'd9);
    expect_rsp(4'd9, 64'hAAAA, "R6 store behind waiters");
    expect_rsp(4'd1, 64'hAAAA, "R6 oldest taker first");
    expect_none(3, "R6 younger takers still wait");
    send(3'd2, 4'd6, 64'hBBBB, 4'd10);
    expect_rsp(4'd10, 64'hBBBB, "R6 second store");
    expect_rsp(4'd2, 64'hBBBB, "R6 second taker");
    send(3'd2, 4'd6, 64'hCCCC, 4'd11);
    expect_rsp(4'd11, 64'hCCCC, "R6 third store");
    expect_rsp(4'd3, 64'hCCCC, "R6 third taker");

    // R7 R8: fill the queue, release through preload
    for (int i = 0; i < 8; i++) send(3'd0, 4'd5, 64'd0, ID_W'(i));
    chk(req_ready == 1'b0, "R7 ready low when queue full", {63'd0, req_ready}, 64'd0);
    expect_none(3, "R7 full queue waits");
    preload(4'd5, 64'h5555_0000_5555_0000);
    for (int i = 0; i < 8; i++)
      expect_rsp(ID_W'(i), 64'h5555_0000_5555_0000, "R8 preload releases in order");
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready back after drain", {63'd0, req_ready}, 64'd1);
    probe(4'd5, 1'b1, 64'h5555_0000_5555_0000, "R8 preloaded word full");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule